// File: doc/BRIEF.md
# Product-Machine Reachability and Equivalence Engine

This block decides whether two fixed binary-input Mealy machines produce the same output stream for every input stream. It does this in hardware. It builds the product of the two machines and finds the reachable part of that product by iterating to a fixed point. It then tests output agreement only over the states it found.

Both component machines are saturating counters. Input 1 advances the counter one state, and it stays in its top state once there. Input 0 sends the counter back to state 0. A machine drives output 1 only when its input is 1 and its state index is at or above a threshold parameter. The defaults give machine A three states with threshold 2, and machine B four states with threshold 2.

The product state set is kept as a one-hot-per-state bit vector. The pair (a, b) sits at bit a*NB + b, so the defaults give 12 bits. A start pulse loads the set with the joint home state. One clock cycle adds every successor of every member under both input values. When a cycle adds nothing, the engine stops and raises a one-cycle completion pulse. It also reports the verdict. The final set, the step count and the verdict are held until the next start.

Top module: `product_reach_engine`

## Requirements
- R1: After reset, done, equiv, iter and reach are all zero.
- R2: A start pulse sampled while the engine is idle loads reach with only bit 0 (the pair (0,0)) on the next cycle. The same edge sets iter to 0 and clears equiv.
- R3: While the engine runs, reach never loses a bit, and bit 0 is always set, because input 0 always leads back to (0,0).
- R4: The engine stops on the first cycle whose image adds no new pair. With the default machines the final reach is 12'hC21, which is the pairs (0,0), (1,1), (2,2) and (2,3).
- R5: iter counts the steps that enlarged the set. With the default machines it ends at 3, and done rises four cycles after the load edge.
- R6: done is high for exactly one cycle per run.
- R7: equiv is 1 exactly when, in every reachable pair, both machines give equal outputs for input 0 and for input 1. This gives 1 for the default machines, and 0 when machine B's threshold is 3, because the two machines disagree in (2,2).
- R8: A start pulse while the engine is running has no effect. The run's set sequence, step count, completion time and verdict are unchanged.
- R9: While idle with no start, reach, iter and equiv hold their values. Their final values stay readable after done falls.
- R10: Intermediate sets appear on reach one per cycle. With the defaults these are 12'h001, 12'h021, 12'h421 and 12'hC21.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run; honoured only when idle |
| done | output | 1 | One-cycle pulse when the fixed point is reached |
| reach | output | NA*NB | Reachable-pair set, bit a*NB+b for pair (a,b) |
| iter | output | ITW | Number of set-enlarging steps in the last run |
| equiv | output | 1 | Verdict of the last run, 1 = machines equivalent |

## Verification
The embedded properties watch four things on every cycle: the set never shrinks during a run, the home pair stays a member, a completion pulse never lasts two cycles, and idle state holds without a start. They also check that an idle start always yields the single-bit initial set. The exact set sequence, the step count of 3 and the completion cycle can only be shown by the bench's scenarios. The same goes for a start pulse during a run being ignored, and for the verdict flipping when one threshold changes, which the bench shows with a second instance.

// File: rtl/pre_pkg.sv
package pre_pkg;

   // successor of one saturating counter state under input 1
   function automatic int sat_step(input int s, input int n);
      return (s + 1 >= n) ? n - 1 : s + 1;
   endfunction

   // flat index of the product successor of pair index p under input 1
   function automatic int pair_step(input int p, input int na, input int nb);
      int a;
      int b;
      a = p / nb;
      b = p % nb;
      return sat_step(a, na) * nb + sat_step(b, nb);
   endfunction

   // Mealy output of a threshold machine
   function automatic logic mealy_out(input int s, input logic in_bit, input int thr);
      return in_bit && (s >= thr);
   endfunction

endpackage

// File: rtl/pre_image.sv
module pre_image #(
   parameter int NA = 3,
   parameter int NB = 4
) (
   input  logic [NA*NB-1:0] cur,
   output logic [NA*NB-1:0] img
);
   import pre_pkg::*;
   localparam int NS = NA * NB;

   // target 0 is reached from any member via input 0
   assign img[0] = |cur;

   for (genvar tg = 1; tg < NS; tg++) begin : g_tgt
      logic hit;
      always_comb begin
         hit = 1'b0;
         for (int src = 0; src < NS; src++) begin
            if (cur[src] && (pair_step(src, NA, NB) == tg)) hit = 1'b1;
         end
      end
      assign img[tg] = hit;
   end

endmodule

// File: rtl/pre_agree.sv
module pre_agree #(
   parameter int NA    = 3,
   parameter int NB    = 4,
   parameter int THR_A = 2,
   parameter int THR_B = 2
) (
   input  logic [NA*NB-1:0] cur,
   output logic             all_agree
);
   import pre_pkg::*;
   localparam int NS = NA * NB;

   logic [NS-1:0] pair_ok;

   for (genvar ga = 0; ga < NA; ga++) begin : g_a
      for (genvar gb = 0; gb < NB; gb++) begin : g_b
         assign pair_ok[ga*NB+gb] =
            (mealy_out(ga, 1'b0, THR_A) == mealy_out(gb, 1'b0, THR_B)) &&
            (mealy_out(ga, 1'b1, THR_A) == mealy_out(gb, 1'b1, THR_B));
      end
   end

   // unreachable pairs are excused
   assign all_agree = &(pair_ok | ~cur);

endmodule

// File: rtl/product_reach_engine.sv
module product_reach_engine #(
   parameter int NA    = 3,
   parameter int NB    = 4,
   parameter int THR_A = 2,
   parameter int THR_B = 2,
   parameter int ITW   = $clog2(NA*NB + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   output logic                done,
   output logic [NA*NB-1:0]    reach,
   output logic [ITW-1:0]      iter,
   output logic                equiv
);
   localparam int NS = NA * NB;
   localparam logic [NS-1:0] HOME = {{(NS-1){1'b0}}, 1'b1};

   if (NA < 2 || NB < 2) begin : g_bad_size
      $error("product_reach_engine: NA and NB must be at least 2");
   end
   if (THR_A < 0 || THR_A >= NA || THR_B < 0 || THR_B >= NB) begin : g_bad_thr
      $error("product_reach_engine: thresholds must index a state");
   end
   if ((1 << ITW) <= NS) begin : g_bad_itw
      $error("product_reach_engine: ITW too narrow for step count");
   end

   typedef enum logic {ST_IDLE, ST_RUN} eng_st_t;
   eng_st_t st;

   logic [NS-1:0] img;
   logic [NS-1:0] nxt;
   logic          fixed;
   logic          agree_now;

   pre_image #(.NA(NA), .NB(NB)) u_image (
      .cur (reach),
      .img (img)
   );

   pre_agree #(.NA(NA), .NB(NB), .THR_A(THR_A), .THR_B(THR_B)) u_agree (
      .cur       (reach),
      .all_agree (agree_now)
   );

   assign nxt   = reach | img;
   assign fixed = (nxt == reach);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         done  <= 1'b0;
         reach <= '0;
         iter  <= '0;
         equiv <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  reach <= HOME;
                  iter  <= '0;
                  equiv <= 1'b0;
                  st    <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (fixed) begin
                  done  <= 1'b1;
                  equiv <= agree_now;
                  st    <= ST_IDLE;
               end else begin
                  reach <= nxt;
                  iter  <= iter + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   a_r2_load_home: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && start) |=> (reach == HOME && iter == '0 && !equiv));

   a_r3_no_shrink: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN) |=> ((reach & $past(reach)) == $past(reach)));

   a_r3_home_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN) |-> reach[0]);

   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r5_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (st == ST_IDLE && reach[0]));

   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !start) |=> ($stable(reach) && $stable(iter) && $stable(equiv)));

endmodule

// File: tb/test_product_reach_engine.sv
module test_product_reach_engine;
   localparam int NS  = 12;
   localparam int ITW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;

   logic           done,  done_b;
   logic [NS-1:0]  reach, reach_b;
   logic [ITW-1:0] iter,  iter_b;
   logic           equiv, equiv_b;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   product_reach_engine i_product_reach_engine (
      .clk(clk), .rst_n(rst_n), .start(start),
      .done(done), .reach(reach), .iter(iter), .equiv(equiv)
   );

   // same machine A, machine B with threshold 3: disagrees in (2,2)
   product_reach_engine #(.THR_B(3)) i_product_reach_engine_alt (
      .clk(clk), .rst_n(rst_n), .start(start),
      .done(done_b), .reach(reach_b), .iter(iter_b), .equiv(equiv_b)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 done",  32'(done),  0);
      chk("R1 reach", 32'(reach), 0);
      chk("R1 iter",  32'(iter),  0);
      chk("R1 equiv", 32'(equiv), 0);
   endtask

   // one full run; poke>0 raises start again for one cycle at that step
   task automatic t_run(input string tag, input int poke);
      logic [NS-1:0] seq [4];
      seq[0] = 12'h001; seq[1] = 12'h021; seq[2] = 12'h421; seq[3] = 12'hC21;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 4; k++) begin
         chk({tag, " R10 set step"}, 32'(reach), 32'(seq[k]));
         chk({tag, " R5 iter step"}, 32'(iter), k);
         chk({tag, " R6 no early done"}, 32'(done), 0);
         if (k == 0) chk({tag, " R2 equiv cleared"}, 32'(equiv), 0);
         if (k == poke) start = 1'b1;   // R8 start during run
         @(negedge clk);
         start = 1'b0;
      end
      chk({tag, " R4 done rises"}, 32'(done), 1);
      chk({tag, " R4 final set"}, 32'(reach), 32'h0C21);
      chk({tag, " R5 final iter"}, 32'(iter), 3);
      chk({tag, " R7 equiv default"}, 32'(equiv), 1);
      chk({tag, " R7 equiv alt"}, 32'(equiv_b), 0);
      chk({tag, " R7 alt set"}, 32'(reach_b), 32'h0C21);
      @(negedge clk);
      chk({tag, " R6 done falls"}, 32'(done), 0);
      chk({tag, " R6 alt done falls"}, 32'(done_b), 0);
   endtask

   task automatic t_hold();
      repeat (5) @(negedge clk);
      chk("R9 hold set",   32'(reach), 32'h0C21);
      chk("R9 hold iter",  32'(iter),  3);
      chk("R9 hold equiv", 32'(equiv), 1);
      chk("R9 no done",    32'(done),  0);
   endtask

   initial begin
      t_reset();
      t_run("plain", -1);
      t_hold();
      t_run("poke1", 1);
      t_run("poke3", 3);
      t_run("restart", -1);
      t_hold();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL R4 watchdog expired actual=hung expected=complete");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

endmodule